// File: doc/BRIEF.md
# USB Transmit Line Serializer

This block is the send half of a USB low-level transceiver interface. A link-layer engine hands it bytes over a parallel bus with a valid/ready handshake. The block turns them into a serial line: a differential drive pair plus an output enable. It adds the synchronization preamble, stuffed bits and NRZI coding, and closes each packet with an end-of-packet sequence. A strobe in the same clock domain sets the bit time, and the line outputs change only on clock edges where that strobe is high.

A packet starts when the link raises its valid signal while the block is idle. The block sends the eight-bit preamble. While the preamble goes out, the block requests bytes one at a time into a single holding register. Each byte is shifted out least significant bit first. When the holding register is empty after the last byte and valid is low, the block drives the end-of-packet sequence and then releases the line. A two-bit mode input selects normal coding, raw bits without stuffing or NRZI, or a non-driving state.

Top module: `usb_tx_serializer`

## Requirements
- R1: After reset and while idle, line_oe is 0, line_dp is 1, line_dn is 0, and tx_ready is 0.
- R2: When tx_valid is sampled high in idle with a driving mode, line_oe rises at the next clock edge on which bit_en is high, and the first symbol is K. With bit_en held high this is exactly one clock after the detecting edge, never at the detecting edge itself.
- R3: Line symbols are encoded as J = (dp 1, dn 0), K = (dp 0, dn 1) and SE0 = (dp 0, dn 0). SE1 is never driven. In normal mode the preamble appears as K J K J K J K K.
- R4: tx_ready is high only while tx_valid is high, a packet is being sent and the holding register is empty. A byte is captured at an edge where tx_valid and tx_ready are both high, and tx_ready is low in the cycle that follows. tx_ready stays low once tx_valid has dropped.
- R5: Data bits are sent least significant bit first, and bytes follow one another with no gap. In normal mode a 0 bit toggles the line level and a 1 bit holds it, starting from J.
- R6: In normal mode, after six consecutive 1 bits (the final preamble bit counts), a 0 bit is inserted before the next bit. This also applies after the last data bit.
- R7: After the last byte has been sent and tx_valid is low, the block drives SE0 for two bit times, then J for one bit time, then drops line_oe.
- R8: In mode 2'b10 (raw), no bits are stuffed and no NRZI coding is applied. A 1 bit is sent as J and a 0 bit as K, so the preamble is K K K K K K K J. The end of packet is the same as in R7.
- R9: In mode 2'b01 and in the reserved mode 2'b11, tx_valid is ignored: line_oe and tx_ready stay 0.
- R10: line_dp, line_dn and line_oe change only on clock edges at which bit_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-time strobe: one line symbol per edge on which it is high |
| op_mode | input | 2 | 00 normal, 01 non-driving, 10 raw, 11 reserved (non-driving) |
| tx_valid | input | 1 | Link has a packet in progress and data on tx_data |
| tx_data | input | DATA_W | Byte offered by the link |
| tx_ready | output | 1 | Holding register empty; byte captured at this edge if tx_valid |
| line_dp | output | 1 | Positive line drive level |
| line_dn | output | 1 | Negative line drive level |
| line_oe | output | 1 | Line driver enable |

## Verification
The properties assume that the link follows the handshake. Once it raises tx_valid, it keeps a byte on tx_data whenever tx_ready is high, holds tx_valid until its last byte has been taken, and only then drops it. They also assume that op_mode changes only while the block is idle with tx_valid low. The stimulus follows these rules. Every packet is driven by one task that advances to the next byte only after a sampled handshake, clears tx_valid after the final one, and sets the mode before tx_valid rises. The strobe period is varied between one, two and four clocks so that the holding register is refilled under both the tightest and looser timing.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_NODRV  = 2'b01,
        MODE_RAW    = 2'b10,
        MODE_RSVD   = 2'b11
    } tx_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_DATA,
        ST_EOP_SE0,
        ST_EOP_J
    } tx_state_e;

    typedef enum logic [2:0] {
        SYM_ZERO,
        SYM_ONE,
        SYM_SE0,
        SYM_J,
        SYM_OFF
    } tx_sym_e;

    typedef struct packed {
        logic dp;
        logic dn;
        logic oe;
    } line_t;

    localparam line_t LINE_IDLE = '{dp: 1'b1, dn: 1'b0, oe: 1'b0};

    function automatic logic mode_drives(input logic [1:0] m);
        return (m == MODE_NORMAL) || (m == MODE_RAW);
    endfunction

    function automatic line_t level_to_line(input logic lvl_j);
        line_t l;
        l.dp = lvl_j;
        l.dn = ~lvl_j;
        l.oe = 1'b1;
        return l;
    endfunction

endpackage

// File: rtl/usb_tx_hold.sv
module usb_tx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] dout
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            dout <= '0;
        end else if (load) begin
            full <= 1'b1;
            dout <= din;
        end else if (take) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/usb_tx_line_enc.sv
module usb_tx_line_enc
    import usb_tx_pkg::*;
#(
    parameter int STUFF_RUN = 6
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    sym_vld,
    input  tx_sym_e sym,
    input  logic    raw,
    output line_t   line,
    output logic    stuff_due
);

    localparam int RUN_W = $clog2(STUFF_RUN + 1);

    logic             lvl_q;
    logic [RUN_W-1:0] ones_q;
    logic             bit_val;
    logic             lvl_next;

    assign bit_val   = (sym == SYM_ONE);
    assign lvl_next  = raw ? bit_val : (bit_val ? lvl_q : ~lvl_q);
    assign stuff_due = !raw && (ones_q == RUN_W'(STUFF_RUN));

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= 1'b1;
            ones_q <= '0;
            line   <= LINE_IDLE;
        end else if (clr) begin
            lvl_q  <= 1'b1;
            ones_q <= '0;
        end else if (sym_vld) begin
            case (sym)
                SYM_ZERO, SYM_ONE: begin
                    lvl_q  <= lvl_next;
                    line   <= level_to_line(lvl_next);
                    ones_q <= (bit_val && !raw) ? ones_q + 1'b1 : '0;
                end
                SYM_SE0: begin
                    line   <= '{dp: 1'b0, dn: 1'b0, oe: 1'b1};
                    ones_q <= '0;
                end
                SYM_J: begin
                    lvl_q <= 1'b1;
                    line  <= level_to_line(1'b1);
                end
                default: begin
                    lvl_q <= 1'b1;
                    line  <= LINE_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/usb_tx_serializer.sv
module usb_tx_serializer
    import usb_tx_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int STUFF_RUN    = 6,
    parameter int EOP_SE0_BITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic [1:0]        op_mode,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              line_dp,
    output logic              line_dn,
    output logic              line_oe
);

    localparam int LEFT_W = $clog2(DATA_W + 1);
    localparam int SYNC_W = $clog2(DATA_W);
    localparam int EOP_W  = $clog2(EOP_SE0_BITS + 1);
    localparam logic [SYNC_W-1:0] SYNC_LAST = SYNC_W'(DATA_W - 1);

    tx_state_e          state_q;
    logic               raw_q;
    logic [DATA_W-1:0]  sh_q;
    logic [LEFT_W-1:0]  left_q;
    logic [SYNC_W-1:0]  sync_idx_q;
    logic [EOP_W-1:0]   eop_cnt_q;

    logic               hold_full;
    logic [DATA_W-1:0]  hold_data;
    logic               load;
    logic               take;
    logic               stuff_due;
    logic               sym_vld;
    tx_sym_e            sym;
    line_t              line;

    assign tx_ready = tx_valid && !hold_full &&
                      ((state_q == ST_SYNC) || (state_q == ST_DATA));
    assign load     = tx_valid && tx_ready;
    assign sym_vld  = bit_en && (state_q != ST_IDLE);

    always_comb begin
        sym  = SYM_OFF;
        take = 1'b0;
        case (state_q)
            ST_SYNC: begin
                if (stuff_due)
                    sym = SYM_ZERO;
                else
                    sym = (sync_idx_q == SYNC_LAST) ? SYM_ONE : SYM_ZERO;
            end
            ST_DATA: begin
                if (stuff_due) begin
                    sym = SYM_ZERO;
                end else if (left_q != '0) begin
                    sym = sh_q[0] ? SYM_ONE : SYM_ZERO;
                end else if (hold_full) begin
                    sym  = hold_data[0] ? SYM_ONE : SYM_ZERO;
                    take = bit_en;
                end else begin
                    sym = SYM_SE0;
                end
            end
            ST_EOP_SE0: sym = (eop_cnt_q < EOP_W'(EOP_SE0_BITS)) ? SYM_SE0 : SYM_J;
            default:    sym = SYM_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            raw_q      <= 1'b0;
            sh_q       <= '0;
            left_q     <= '0;
            sync_idx_q <= '0;
            eop_cnt_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (tx_valid && mode_drives(op_mode)) begin
                        state_q    <= ST_SYNC;
                        raw_q      <= (op_mode == MODE_RAW);
                        sync_idx_q <= '0;
                    end
                end
                ST_SYNC: begin
                    if (bit_en && !stuff_due) begin
                        if (sync_idx_q == SYNC_LAST) begin
                            state_q <= ST_DATA;
                            left_q  <= '0;
                        end else begin
                            sync_idx_q <= sync_idx_q + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (bit_en && !stuff_due) begin
                        if (left_q != '0) begin
                            sh_q   <= sh_q >> 1;
                            left_q <= left_q - 1'b1;
                        end else if (hold_full) begin
                            sh_q   <= hold_data >> 1;
                            left_q <= LEFT_W'(DATA_W - 1);
                        end else begin
                            state_q   <= ST_EOP_SE0;
                            eop_cnt_q <= EOP_W'(1);
                        end
                    end
                end
                ST_EOP_SE0: begin
                    if (bit_en) begin
                        if (eop_cnt_q < EOP_W'(EOP_SE0_BITS))
                            eop_cnt_q <= eop_cnt_q + 1'b1;
                        else
                            state_q <= ST_EOP_J;
                    end
                end
                ST_EOP_J: begin
                    if (bit_en)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    usb_tx_hold #(
        .W (DATA_W)
    ) i_hold (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .din  (tx_data),
        .take (take),
        .full (hold_full),
        .dout (hold_data)
    );

    usb_tx_line_enc #(
        .STUFF_RUN (STUFF_RUN)
    ) i_enc (
        .clk       (clk),
        .rst       (rst),
        .clr       (state_q == ST_IDLE),
        .sym_vld   (sym_vld),
        .sym       (sym),
        .raw       (raw_q),
        .line      (line),
        .stuff_due (stuff_due)
    );

    assign line_dp = line.dp;
    assign line_dn = line.dn;
    assign line_oe = line.oe;

endmodule

// File: rtl/usb_tx_serializer_chk.sv
module usb_tx_serializer_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_en,
    input logic [1:0] op_mode,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       line_dp,
    input logic       line_dn,
    input logic       line_oe
);

    AST_LINE_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable({line_dp, line_dn, line_oe})); // R10

    AST_NO_SE1: assert property (@(posedge clk) disable iff (rst)
        line_oe |-> !(line_dp && line_dn)); // R3

    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> tx_valid); // R4

    AST_READY_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready); // R4

    AST_FIRST_SYMBOL_K: assert property (@(posedge clk) disable iff (rst)
        $rose(line_oe) |-> (!line_dp && line_dn)); // R2

    AST_RELEASE_AFTER_J: assert property (@(posedge clk) disable iff (rst)
        $fell(line_oe) |-> $past(line_dp && !line_dn)); // R7

    AST_NODRIVE_STAYS_OFF: assert property (@(posedge clk) disable iff (rst)
        (op_mode[0] && $stable(op_mode) && !line_oe && !tx_ready) |=> !line_oe); // R9

endmodule

bind usb_tx_serializer usb_tx_serializer_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .op_mode  (op_mode),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .line_dp  (line_dp),
    .line_dn  (line_dn),
    .line_oe  (line_oe)
);

// File: tb/test_usb_tx_serializer.sv
module test_usb_tx_serializer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic [1:0] op_mode = 2'b00;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_ready;
    logic       line_dp;
    logic       line_dn;
    logic       line_oe;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    usb_tx_serializer i_usb_tx_serializer (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .op_mode  (op_mode),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .line_dp  (line_dp),
        .line_dn  (line_dn),
        .line_oe  (line_oe)
    );

    // codes: 0 SE0, 1 J, 2 K, 3 released, 4 SE1
    localparam int C_SE0 = 0, C_J = 1, C_K = 2, C_OFF = 3;

    // {mode[39:38], nbytes[37:36], strobe period[35:32], spare[31:24], bytes[23:0] (first in [7:0])}
    localparam int NVEC = 6;
    localparam logic [39:0] VEC [NVEC] = '{
        {2'd0, 2'd1, 4'd4, 8'h00, 24'h0000A5},
        {2'd0, 2'd2, 4'd4, 8'h00, 24'h00FFFF},
        {2'd0, 2'd1, 4'd1, 8'h00, 24'h0000FC},
        {2'd2, 2'd2, 4'd4, 8'h00, 24'h0000FF},
        {2'd0, 2'd3, 4'd2, 8'h00, 24'h817E00},
        {2'd2, 2'd1, 4'd1, 8'h00, 24'h00003C}
    };

    int   be_per = 4;
    int   be_cnt = 0;
    logic cap_on = 1'b0;
    logic cap_done = 1'b0;
    int   ncap = 0;
    int   cap [64];
    int   expv [64];
    int   nexp;
    logic [2:0] prev_line;
    logic trk = 1'b0;
    int   r10_bad = 0;

    function automatic int sym_code();
        if (!line_oe) return C_OFF;
        if (line_dp && !line_dn) return C_J;
        if (!line_dp && line_dn) return C_K;
        if (!line_dp && !line_dn) return C_SE0;
        return 4;
    endfunction

    always @(negedge clk) begin
        if (trk && !bit_en && ({line_dp, line_dn, line_oe} != prev_line))
            r10_bad++;
        prev_line = {line_dp, line_dn, line_oe};
        trk = !rst;
        if (bit_en && cap_on && !cap_done && (line_oe || ncap > 0) && ncap < 64) begin
            cap[ncap] = sym_code();
            if (cap[ncap] == C_OFF) cap_done = 1'b1;
            ncap++;
        end
        be_cnt = (be_cnt + 1 >= be_per) ? 0 : be_cnt + 1;
        bit_en = (be_cnt == 0);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input int c);
        expv[nexp] = c;
        nexp++;
    endtask

    task automatic build_expected(input logic [1:0] mode, input int nb, input logic [23:0] bytes);
        logic lvl;
        int   ones;
        logic b;
        lvl  = 1'b1;
        ones = 0;
        nexp = 0;
        for (int i = 0; i < 8 * (nb + 1); i++) begin
            b = (i < 8) ? (i == 7) : bytes[i - 8];
            if (mode == 2'b10) begin
                push(b ? C_J : C_K);
            end else begin
                if (!b) lvl = ~lvl;
                push(lvl ? C_J : C_K);
                ones = b ? ones + 1 : 0;
                if (ones == 6) begin
                    lvl  = ~lvl;
                    push(lvl ? C_J : C_K);
                    ones = 0;
                end
            end
        end
        push(C_SE0);
        push(C_SE0);
        push(C_J);
        push(C_OFF);
    endtask

    task automatic send_packet(input logic [1:0] mode, input int nb, input int per,
                               input logic [23:0] bytes, input string req);
        int   idx;
        logic r;
        int   bad_rdy;
        int   mism;
        @(negedge clk);
        be_per   = per;
        op_mode  = mode;
        ncap     = 0;
        cap_done = 1'b0;
        cap_on   = 1'b1;
        build_expected(mode, nb, bytes);
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data  = bytes[7:0];
        idx = 0;
        #1 r = tx_ready;
        while (idx < nb) begin
            @(negedge clk);
            if (r) begin
                idx++;
                if (idx < nb) tx_data = bytes[8*idx +: 8];
                else tx_valid = 1'b0;
            end
            #1 r = tx_ready;
        end
        bad_rdy = 0;
        while (!cap_done) begin
            @(negedge clk);
            #1 if (tx_ready) bad_rdy++;
        end
        cap_on = 1'b0;
        check(bad_rdy == 0, "R4 ready after valid dropped", bad_rdy, 0);
        mism = -1;
        for (int i = 0; i < nexp; i++)
            if (mism < 0 && (i >= ncap || cap[i] != expv[i])) mism = i;
        if (ncap != nexp && mism < 0) mism = nexp;
        if (mism < 0)
            check(1'b1, req, 0, 0);
        else if (mism < ncap && mism < nexp)
            check(1'b0, $sformatf("%s symbol %0d (len %0d/%0d)", req, mism, ncap, nexp),
                  cap[mism], expv[mism]);
        else
            check(1'b0, $sformatf("%s trace length", req), ncap, nexp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int bad;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!line_oe && line_dp && !line_dn && !tx_ready, "R1 reset/idle line",
              {line_oe, line_dp, line_dn, tx_ready}, 4'b0100);

        // table of packets: R3 R5 R6 R7 (normal) and R8 (raw)
        for (int v = 0; v < NVEC; v++) begin
            send_packet(VEC[v][39:38], int'(VEC[v][37:36]), int'(VEC[v][35:32]), VEC[v][23:0],
                        (VEC[v][39:38] == 2'b10) ? "R8 raw trace" : "R3 R5 R6 R7 coded trace");
            repeat (3) @(negedge clk);
        end

        // R2 start latency with strobe every clock
        be_per  = 1;
        op_mode = 2'b00;
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data  = 8'h5A;
        @(negedge clk);
        check(!line_oe, "R2 no drive at detecting edge", line_oe, 0);
        check(tx_ready, "R4 ready once packet started", tx_ready, 1);
        @(negedge clk);
        tx_valid = 1'b0;
        check(line_oe && !line_dp && line_dn, "R2 first K one clock later",
              {line_oe, line_dp, line_dn}, 3'b101);
        bad = 0;
        while (line_oe && bad < 200) begin
            @(negedge clk);
            bad++;
        end
        check(!line_oe, "R7 line released", line_oe, 0);

        // R9 non-driving modes ignore tx_valid
        for (int m = 1; m < 4; m += 2) begin
            be_per = 2;
            @(negedge clk);
            op_mode  = 2'(m);
            @(negedge clk);
            tx_valid = 1'b1;
            bad = 0;
            repeat (40) begin
                @(negedge clk);
                #1 if (line_oe || tx_ready) bad++;
            end
            tx_valid = 1'b0;
            check(bad == 0, $sformatf("R9 mode %0d stays off", m), bad, 0);
            @(negedge clk);
            op_mode = 2'b00;
        end

        repeat (4) @(negedge clk);
        check(r10_bad == 0, "R10 changes only on strobe", r10_bad, 0);
        check(!line_oe && line_dp && !line_dn && !tx_ready, "R1 idle after traffic",
              {line_oe, line_dp, line_dn, tx_ready}, 4'b0100);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule